// File: doc/BRIEF.md
# DMA Request Gating Control Register

This block is a 32-bit memory-mapped control register that sits between an audio serial port's FIFO logic and a DMA controller. It holds one activity flag for the transmit direction and one for the receive direction. Software sets a flag after it has started the matching DMA channel. While a flag is set, the raw data request from the FIFO logic for that direction passes through to the DMA controller. While it is clear, the request to the controller stays low.

Each flag clears itself when the FIFO logic signals that a DMA packet has finished in its direction. Software must therefore re-arm the request path before every packet. The gated request drops in the same cycle as the packet-complete pulse, so the controller never sees a stray request after a packet has ended. A software reset input clears both flags, and so does the synchronous active-high reset.

Top module: `dma_req_gate_reg`

## Requirements
- R1: The transmit flag sits at bit 16 and the receive flag at bit 0. When `reg_sel` is high and `reg_wr` is low, `reg_rdata` returns both flags in those positions. In every other cycle `reg_rdata` is all zeros.
- R2: All bits other than 16 and 0 are reserved. Writes to them have no effect, and they always read as 0.
- R3: After `rst`, both flags are 0.
- R4: When `sw_rst` is high, both flags are 0 at the next edge, whatever write occurs in that cycle. Both gated requests are low during that cycle.
- R5: While a direction's flag is 0, its gated request output is low for any raw request value.
- R6: While a direction's flag is 1 and no packet-complete or software reset is present, its gated request equals its raw request.
- R7: A write (`reg_sel` and `reg_wr` both high) loads bit 16 of the write data into the transmit flag and bit 0 into the receive flag. A 1 sets the flag and a 0 clears it.
- R8: A packet-complete pulse clears that direction's flag at the next edge and leaves the other flag unchanged.
- R9: If a packet-complete pulse and a write of 1 to the same flag occur in the same cycle, the flag ends at 0.
- R10: In any cycle where a direction's packet-complete pulse is high, that direction's gated request output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software reset; clears both flags |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe (a read when low while selected) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| tx_req_raw | input | 1 | Raw transmit data request from FIFO logic |
| rx_req_raw | input | 1 | Raw receive data request from FIFO logic |
| tx_pkt_done | input | 1 | Transmit DMA packet complete pulse |
| rx_pkt_done | input | 1 | Receive DMA packet complete pulse |
| tx_dma_req | output | 1 | Gated transmit request to the DMA controller |
| rx_dma_req | output | 1 | Gated receive request to the DMA controller |

## Verification
The hardest situations to reach are the ones where two flag updates collide in a single cycle. Examples are a packet-complete pulse landing together with a software write of 1 to the same flag, or a software reset landing together with a write. Directed cycles place each collision explicitly. After that, a long random phase drives writes, completions, software resets and raw requests independently each cycle. Completions are rare enough that flags stay armed long enough for those overlaps to recur with both flags set.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

    localparam int REG_W   = 32;
    localparam int TX_POS  = 16;
    localparam int RX_POS  = 0;
    localparam int NUM_DIR = 2;

    typedef enum logic [0:0] {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    // Per-direction stimulus seen by one flag cell
    typedef struct packed {
        logic raw_req;
        logic pkt_done;
        logic wr;
        logic wbit;
    } dir_in_t;

    // Per-direction result from one flag cell
    typedef struct packed {
        logic flag;
        logic req;
    } dir_out_t;

    function automatic int unsigned dir_pos(input int unsigned d,
                                            input int unsigned tx_pos,
                                            input int unsigned rx_pos);
        return (d == int'(DIR_TX)) ? tx_pos : rx_pos;
    endfunction

endpackage

// File: rtl/dma_gate_flag.sv
module dma_gate_flag
    import dma_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sw_rst,
    input  dir_in_t  din,
    output dir_out_t dout
);

    logic flag_q;
    logic flag_d;

    // Priority: software reset, then packet completion, then software write
    always_comb begin
        flag_d = flag_q;
        if (sw_rst || din.pkt_done) begin
            flag_d = 1'b0;
        end else if (din.wr) begin
            flag_d = din.wbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign dout.flag = flag_q;
    assign dout.req  = flag_q & din.raw_req & ~din.pkt_done & ~sw_rst;

    AST_GATE_OFF:   assert property (@(posedge clk) disable iff (rst) !dout.flag |-> !dout.req);                      // R5
    AST_DONE_DROP:  assert property (@(posedge clk) disable iff (rst) din.pkt_done |-> !dout.req);                    // R10
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst) din.pkt_done |=> !dout.flag);                   // R8
    AST_DONE_WINS:  assert property (@(posedge clk) disable iff (rst) (din.pkt_done && din.wr && din.wbit) |=> !dout.flag); // R9
    AST_SWRST:      assert property (@(posedge clk) disable iff (rst) sw_rst |=> !dout.flag);                         // R4
    AST_WR_SET:     assert property (@(posedge clk) disable iff (rst) (din.wr && din.wbit && !din.pkt_done && !sw_rst) |=> dout.flag); // R7
    AST_PASS:       assert property (@(posedge clk) disable iff (rst) (dout.flag && !din.pkt_done && !sw_rst) |-> (dout.req == din.raw_req)); // R6
    AST_RST_CLEAR:  assert property (@(posedge clk) rst |=> !dout.flag);                                               // R3

endmodule

// File: rtl/dma_gate_rdmux.sv
module dma_gate_rdmux
    import dma_gate_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int POS_T = TX_POS,
    parameter int POS_R = RX_POS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [NUM_DIR-1:0]  flags,
    output logic [W-1:0]        rdata
);

    localparam logic [W-1:0] LIVE_MASK = (W'(1) << POS_T) | (W'(1) << POS_R);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == POS_T) begin : g_tx
            assign rdata[b] = rd_en & flags[DIR_TX];
        end else if (b == POS_R) begin : g_rx
            assign rdata[b] = rd_en & flags[DIR_RX];
        end else begin : g_rsvd
            assign rdata[b] = 1'b0;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) (rdata & ~LIVE_MASK) == '0);     // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !rd_en |-> (rdata == '0));        // R1

endmodule

// File: rtl/dma_req_gate_reg.sv
module dma_req_gate_reg
    import dma_gate_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int POS_T = TX_POS,
    parameter int POS_R = RX_POS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_rst,
    input  logic         reg_sel,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         tx_req_raw,
    input  logic         rx_req_raw,
    input  logic         tx_pkt_done,
    input  logic         rx_pkt_done,
    output logic         tx_dma_req,
    output logic         rx_dma_req
);

    logic                 wr_en;
    logic                 rd_en;
    logic [NUM_DIR-1:0]   raw_v;
    logic [NUM_DIR-1:0]   done_v;
    logic [NUM_DIR-1:0]   flag_v;
    logic [NUM_DIR-1:0]   req_v;

    assign wr_en = reg_sel & reg_wr;
    assign rd_en = reg_sel & ~reg_wr;

    assign raw_v[DIR_TX]  = tx_req_raw;
    assign raw_v[DIR_RX]  = rx_req_raw;
    assign done_v[DIR_TX] = tx_pkt_done;
    assign done_v[DIR_RX] = rx_pkt_done;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam int unsigned BPOS = dir_pos(d, POS_T, POS_R);
        dir_in_t  din;
        dir_out_t dout;

        assign din.raw_req  = raw_v[d];
        assign din.pkt_done = done_v[d];
        assign din.wr       = wr_en;
        assign din.wbit     = reg_wdata[BPOS];

        dma_gate_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .sw_rst (sw_rst),
            .din    (din),
            .dout   (dout)
        );

        assign flag_v[d] = dout.flag;
        assign req_v[d]  = dout.req;
    end

    dma_gate_rdmux #(
        .W     (W),
        .POS_T (POS_T),
        .POS_R (POS_R)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .flags (flag_v),
        .rdata (reg_rdata)
    );

    assign tx_dma_req = req_v[DIR_TX];
    assign rx_dma_req = req_v[DIR_RX];

    AST_TX_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (tx_pkt_done && !rx_pkt_done && !wr_en && !sw_rst) |=> $stable(flag_v[DIR_RX]));   // R8
    AST_RX_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (rx_pkt_done && !tx_pkt_done && !wr_en && !sw_rst) |=> $stable(flag_v[DIR_TX]));   // R8

endmodule

// File: tb/sim_dma_req_gate_reg.sv
module sim_dma_req_gate_reg;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_rst = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_req_raw = 1'b0;
    logic        rx_req_raw = 1'b0;
    logic        tx_pkt_done = 1'b0;
    logic        rx_pkt_done = 1'b0;
    logic        tx_dma_req;
    logic        rx_dma_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench model of the two flags
    logic m_tx = 1'b0;
    logic m_rx = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_gate_reg u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_req_raw(tx_req_raw), .rx_req_raw(rx_req_raw),
        .tx_pkt_done(tx_pkt_done), .rx_pkt_done(rx_pkt_done),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    function automatic logic [31:0] exp_rdata(logic sel, logic wr, logic tf, logic rf);
        return (sel && !wr) ? ({15'd0, tf, 15'd0, rf}) : 32'd0;
    endfunction

    function automatic logic exp_req(logic f, logic raw, logic done, logic swr);
        return f & raw & ~done & ~swr;
    endfunction

    function automatic logic next_flag(logic f, logic swr, logic done, logic wr_en, logic wb);
        if (swr || done) return 1'b0;
        if (wr_en) return wb;
        return f;
    endfunction

    function automatic string req_tag(logic f, logic done, logic swr, string forced);
        if (forced != "") return forced;
        if (swr)  return "R4";
        if (!f)   return "R5";
        if (done) return "R10";
        return "R6";
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check, advance the model at the rising edge
    task automatic cyc(logic sel, logic wr, logic [31:0] wd, logic txr, logic rxr,
                       logic txd, logic rxd, logic swr, string tag);
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        tx_req_raw = txr; rx_req_raw = rxr;
        tx_pkt_done = txd; rx_pkt_done = rxd; sw_rst = swr;
        #1;
        check((tag != "") ? tag : "R1", "rdata", reg_rdata, exp_rdata(sel, wr, m_tx, m_rx));
        check(req_tag(m_tx, txd, swr, tag), "tx_dma_req", 32'(tx_dma_req), 32'(exp_req(m_tx, txr, txd, swr)));
        check(req_tag(m_rx, rxd, swr, tag), "rx_dma_req", 32'(rx_dma_req), 32'(exp_req(m_rx, rxr, rxd, swr)));
        @(posedge clk);
        m_tx = next_flag(m_tx, swr, txd, sel && wr, wd[16]);
        m_rx = next_flag(m_rx, swr, rxd, sel && wr, wd[0]);
        @(negedge clk);
    endtask

    task automatic rd(string tag);
        cyc(1'b1, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        rst = 1'b0;

        rd("R3");                                                          // reset state
        cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2"); // reserved bits written
        rd("R2");                                                          // reads 0x00010001
        cyc(1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        cyc(1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R10");        // tx done drops same cycle
        rd("R8");                                                          // rx still set
        cyc(1'b1, 1'b1, 32'h0001_0001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");  // write 1 with done
        rd("R9");
        cyc(1'b1, 1'b1, 32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");  // set tx, clear rx
        rd("R7");
        cyc(1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");  // write 0 clears
        rd("R7");
        cyc(1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        cyc(1'b1, 1'b1, 32'h0001_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R4");  // sw reset beats write
        rd("R4");
        cyc(1'b1, 1'b1, 32'h0001_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        cyc(1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R10");         // rx done only
        rd("R8");                                                          // tx still set

        for (int i = 0; i < 3000; i++) begin
            logic sel, wr, swr, txd, rxd;
            sel = ($urandom % 3) == 0;
            wr  = ($urandom % 2) == 0;
            swr = ($urandom % 40) == 0;
            txd = ($urandom % 8) == 0;
            rxd = ($urandom % 8) == 0;
            cyc(sel, wr, $urandom, 1'($urandom), 1'($urandom), txd, rxd, swr, "");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule